// File: doc/BRIEF.md
# Video Field Detector and Register-Set Mapper

This block works out whether the current video field is odd or even by looking at where the active vertical sync edge falls relative to the horizontal sync. It then uses that field flag to pick one of two register sets for a downstream scaler. The sync pair comes from one of two sources, either a decoder port or an expansion port, chosen by a control bit. The active edge of each sync signal is programmable.

There are three field-detection behaviours. Direct detection judges every field on its own. Locked detection only follows the measured phase after it has repeated for a programmable number of fields. Forced toggling inverts the flag on every vertical event. The field flag is then mapped onto the register-set select in one of four ways: straight, inverted, forced to set A or forced to set B. The select only moves at an active vertical edge, so a field never changes register set partway through.

The window length `WIN` and the lock depth `LOCK` are parameters. Defaults are WIN = 4 and LOCK = 3.

Top module: `vfield_mapper`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `field_o`, `set_sel_o` and `stable_o` are 0.
- R2: With `det_mode` = 0 (direct), `field_o` takes a new value at every active vertical edge. The value is 1 when an active horizontal edge occurred in the same cycle or within the WIN preceding cycles, and 0 otherwise. The new value is visible in the cycle after the vertical edge.
- R3: With `det_mode` = 1 (locked), an active vertical edge loads the measured phase into `field_o` only when the phase has been equal on the last LOCK vertical edges, counting this one. Otherwise `field_o` holds its value.
- R4: With `det_mode` = 2 (toggle), `field_o` inverts at every active vertical edge, and horizontal sync has no effect.
- R5: `det_mode` = 3 behaves exactly like `det_mode` = 0.
- R6: With `src_exp` = 1, detection uses `exp_h`/`exp_v`. With `src_exp` = 0, it uses `dec_h`/`dec_v`. Activity on the pair that is not selected has no effect on any output.
- R7: When `h_rise` is 1, the active horizontal edge is the rising edge; when it is 0, the active edge is the falling edge. `v_rise` selects the vertical edge in the same way.
- R8: At an active vertical edge, `set_sel_o` is loaded from the new field value according to `map_mode`: 0 gives the field, 1 gives the inverted field, 2 gives 0 (set A) and 3 gives 1 (set B).
- R9: `set_sel_o` and `field_o` change only in the cycle after an active vertical edge. A change of `map_mode` or `det_mode` between vertical edges does not alter them.
- R10: `stable_o` is 1 exactly when the measured phase has been equal on the last LOCK active vertical edges. It returns to 0 on the first vertical edge whose phase differs. This tracking runs in every detection mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_h | input | 1 | Horizontal sync from the decoder port |
| dec_v | input | 1 | Vertical sync from the decoder port |
| exp_h | input | 1 | Horizontal sync from the expansion port |
| exp_v | input | 1 | Vertical sync from the expansion port |
| src_exp | input | 1 | 1 selects the expansion-port pair, 0 selects the decoder pair |
| h_rise | input | 1 | 1: rising horizontal edge is active, 0: falling edge |
| v_rise | input | 1 | 1: rising vertical edge is active, 0: falling edge |
| det_mode | input | 2 | 0 direct, 1 locked, 2 toggle, 3 direct |
| map_mode | input | 2 | 0 field, 1 inverted field, 2 set A, 3 set B |
| field_o | output | 1 | Detected field flag (1 = odd) |
| set_sel_o | output | 1 | Register-set select (0 = A, 1 = B) |
| stable_o | output | 1 | Phase has been steady for LOCK fields |

## Verification
The bench places vertical edges exactly at the window boundary: in the same cycle as the horizontal edge, WIN cycles after it and WIN+1 cycles after it. An off-by-one window would misjudge the field at the last of these.

For locked detection, the bench runs streaks of LOCK-1 and LOCK equal phases and then breaks a streak. A lock that engages one field early or late, or a `stable_o` that stays high after a phase change, is caught in the cycle it occurs.

The bench also changes `map_mode` and `det_mode` mid-field, reverses both edge polarities and drives noise on the unselected sync pair. These expose a select that moves outside a vertical edge, a polarity applied to the wrong signal, or a source mux that leaks.

// File: rtl/vfm_pkg.sv
package vfm_pkg;
   typedef enum logic [1:0] {
      DET_DIRECT = 2'd0,
      DET_LOCKED = 2'd1,
      DET_TOGGLE = 2'd2,
      DET_SPARE  = 2'd3
   } det_mode_e;

   typedef enum logic [1:0] {
      MAP_FIELD = 2'd0,
      MAP_INV   = 2'd1,
      MAP_SETA  = 2'd2,
      MAP_SETB  = 2'd3
   } map_mode_e;

   localparam int unsigned SYNC_H = 0;
   localparam int unsigned SYNC_V = 1;
   localparam int unsigned SYNC_N = 2;
endpackage

// File: rtl/vfm_edge.sv
module vfm_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic rise_sel,
   output logic ev
);
   logic norm;
   logic norm_q;

   // normalise so that the active edge is always a low-to-high step
   assign norm = rise_sel ? raw : ~raw;
   assign ev   = norm & ~norm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) norm_q <= 1'b0;
      else        norm_q <= norm;
   end
endmodule

// File: rtl/vfm_phase_win.sv
module vfm_phase_win #(
   parameter int unsigned WIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic h_ev,
   output logic in_win
);
   localparam int unsigned CW = $clog2(WIN + 1);
   localparam logic [CW-1:0] CLOAD = CW'(WIN);

   logic [CW-1:0] cnt_q;

   assign in_win = h_ev | (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (h_ev)           cnt_q <= CLOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/vfm_lock_track.sv
module vfm_lock_track #(
   parameter int unsigned LOCK = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic v_ev,
   input  logic phase,
   output logic lock_nx,
   output logic stable
);
   localparam int unsigned RW = $clog2(LOCK + 1);
   localparam logic [RW-1:0] RMAX = RW'(LOCK);

   logic [RW-1:0] run_q;
   logic [RW-1:0] run_nx;
   logic          last_q;

   always_comb begin
      if (run_q != '0 && phase == last_q)
         run_nx = (run_q == RMAX) ? RMAX : run_q + 1'b1;
      else
         run_nx = RW'(1);
   end

   assign lock_nx = (run_nx == RMAX);
   assign stable  = (run_q == RMAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         last_q <= 1'b0;
      end else if (v_ev) begin
         run_q  <= run_nx;
         last_q <= phase;
      end
   end
endmodule

// File: rtl/vfield_mapper.sv
module vfield_mapper #(
   parameter int unsigned WIN  = 4,
   parameter int unsigned LOCK = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dec_h,
   input  logic       dec_v,
   input  logic       exp_h,
   input  logic       exp_v,
   input  logic       src_exp,
   input  logic       h_rise,
   input  logic       v_rise,
   input  logic [1:0] det_mode,
   input  logic [1:0] map_mode,
   output logic       field_o,
   output logic       set_sel_o,
   output logic       stable_o
);
   import vfm_pkg::*;

   generate
      if (WIN < 1) begin : g_bad_win
         $error("vfield_mapper: WIN must be at least 1");
      end
      if (LOCK < 2) begin : g_bad_lock
         $error("vfield_mapper: LOCK must be at least 2");
      end
   endgenerate

   logic [SYNC_N-1:0] raw_s;
   logic [SYNC_N-1:0] rise_s;
   logic [SYNC_N-1:0] ev_s;
   logic              h_ev;
   logic              v_ev;
   logic              phase;
   logic              lock_nx;
   logic              fld_nx;
   logic              sel_nx;
   logic              field_q;
   logic              sel_q;
   det_mode_e         dmode;
   map_mode_e         mmode;

   assign raw_s[SYNC_H]  = src_exp ? exp_h : dec_h;
   assign raw_s[SYNC_V]  = src_exp ? exp_v : dec_v;
   assign rise_s[SYNC_H] = h_rise;
   assign rise_s[SYNC_V] = v_rise;

   for (genvar gi = 0; gi < SYNC_N; gi++) begin : g_edge
      vfm_edge u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw      (raw_s[gi]),
         .rise_sel (rise_s[gi]),
         .ev       (ev_s[gi])
      );
   end

   assign h_ev = ev_s[SYNC_H];
   assign v_ev = ev_s[SYNC_V];

   vfm_phase_win #(.WIN(WIN)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .h_ev   (h_ev),
      .in_win (phase)
   );

   vfm_lock_track #(.LOCK(LOCK)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .v_ev    (v_ev),
      .phase   (phase),
      .lock_nx (lock_nx),
      .stable  (stable_o)
   );

   assign dmode = det_mode_e'(det_mode);
   assign mmode = map_mode_e'(map_mode);

   always_comb begin
      unique case (dmode)
         DET_TOGGLE: fld_nx = ~field_q;
         DET_LOCKED: fld_nx = lock_nx ? phase : field_q;
         default:    fld_nx = phase;
      endcase
   end

   always_comb begin
      unique case (mmode)
         MAP_FIELD: sel_nx = fld_nx;
         MAP_INV:   sel_nx = ~fld_nx;
         MAP_SETA:  sel_nx = 1'b0;
         default:   sel_nx = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field_q <= 1'b0;
         sel_q   <= 1'b0;
      end else if (v_ev) begin
         field_q <= fld_nx;
         sel_q   <= sel_nx;
      end
   end

   assign field_o   = field_q;
   assign set_sel_o = sel_q;
endmodule

// File: rtl/vfm_chk.sv
module vfm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       v_ev,
   input logic [1:0] det_mode,
   input logic [1:0] map_mode,
   input logic       field_o,
   input logic       set_sel_o,
   input logic       stable_o
);
   AST_SEL_HOLD_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !v_ev |=> $stable(set_sel_o)); // R9

   AST_FIELD_HOLD_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !v_ev |=> $stable(field_o)); // R2

   AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (v_ev && det_mode == 2'd2) |=> (field_o != $past(field_o))); // R4

   AST_FORCED_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
      (v_ev && map_mode == 2'd2) |=> !set_sel_o); // R8

   AST_FORCED_SET_B: assert property (@(posedge clk) disable iff (!rst_n)
      (v_ev && map_mode == 2'd3) |=> set_sel_o); // R8

   AST_STABLE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stable_o) |-> $past(v_ev)); // R10
endmodule

bind vfield_mapper vfm_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .v_ev      (v_ev),
   .det_mode  (det_mode),
   .map_mode  (map_mode),
   .field_o   (field_o),
   .set_sel_o (set_sel_o),
   .stable_o  (stable_o)
);

// File: tb/vfield_mapper_tb.sv
module vfield_mapper_tb;
   localparam int WIN  = 4;
   localparam int LOCK = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dec_h = 1'b0, dec_v = 1'b0, exp_h = 1'b0, exp_v = 1'b0;
   logic       src_exp = 1'b0, h_rise = 1'b1, v_rise = 1'b1;
   logic [1:0] det_mode = 2'd0, map_mode = 2'd0;
   logic       field_o, set_sel_o, stable_o;

   int checks = 0;
   int errors = 0;
   string tag_f = "R2";
   string tag_s = "R8";
   bit    done = 1'b0;

   // reference model state
   int m_ph, m_pv, m_cnt, m_fld, m_sel, m_run, m_last;

   always #4 clk = ~clk;

   vfield_mapper #(.WIN(WIN), .LOCK(LOCK)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .dec_h(dec_h), .dec_v(dec_v), .exp_h(exp_h), .exp_v(exp_v),
      .src_exp(src_exp), .h_rise(h_rise), .v_rise(v_rise),
      .det_mode(det_mode), .map_mode(map_mode),
      .field_o(field_o), .set_sel_o(set_sel_o), .stable_o(stable_o)
   );

   always @(posedge clk) begin
      int hs, vs, hn, vn, he, ve, inwin;
      if (!rst_n) begin
         m_ph = 0; m_pv = 0; m_cnt = 0; m_fld = 0; m_sel = 0; m_run = 0; m_last = 0;
      end else begin
         hs = src_exp ? exp_h : dec_h;
         vs = src_exp ? exp_v : dec_v;
         hn = h_rise ? hs : !hs;
         vn = v_rise ? vs : !vs;
         he = hn && !m_ph;
         ve = vn && !m_pv;
         inwin = (he || m_cnt > 0) ? 1 : 0;
         if (ve) begin
            if (m_run > 0 && inwin == m_last) m_run = (m_run < LOCK) ? m_run + 1 : LOCK;
            else m_run = 1;
            m_last = inwin;
            case (det_mode)
               2'd2: m_fld = !m_fld;
               2'd1: if (m_run == LOCK) m_fld = inwin;
               default: m_fld = inwin;
            endcase
            case (map_mode)
               2'd0: m_sel = m_fld;
               2'd1: m_sel = !m_fld;
               2'd2: m_sel = 0;
               default: m_sel = 1;
            endcase
         end
         if (he) m_cnt = WIN;
         else if (m_cnt > 0) m_cnt = m_cnt - 1;
         m_ph = hn;
         m_pv = vn;
      end
   end

   task automatic check(string req, int act, int exp_v_);
      checks++;
      if (act != exp_v_) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v_, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag_f, field_o, m_fld);
         check(tag_s, set_sel_o, m_sel);
         check("R10", stable_o, (m_run == LOCK) ? 1 : 0);
      end
   end

   // one cycle of stimulus; ha/va are active levels of the selected pair
   task automatic drive(bit ha, bit va, bit noise = 1'b0);
      bit hl, vl;
      hl = h_rise ? ha : !ha;
      vl = v_rise ? va : !va;
      if (src_exp) begin
         exp_h = hl; exp_v = vl;
         if (noise) begin dec_h = 1'($urandom_range(1)); dec_v = 1'($urandom_range(1)); end
      end else begin
         dec_h = hl; dec_v = vl;
         if (noise) begin exp_h = 1'($urandom_range(1)); exp_v = 1'($urandom_range(1)); end
      end
      @(negedge clk);
      #1;
   endtask

   // H active edge, vertical edge off cycles later, then quiet time
   task automatic frame(int off, bit noise = 1'b0);
      if (off == 0) drive(1, 1, noise);
      else begin
         drive(1, 0, noise);
         for (int i = 1; i < off; i++) drive(0, 0, noise);
         drive(0, 1, noise);
      end
      drive(0, 1, noise);
      for (int i = 0; i < WIN + 3; i++) drive(0, 0, noise);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1", field_o, 0);
      check("R1", set_sel_o, 0);
      check("R1", stable_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", field_o, 0);
      check("R1", stable_o, 0);
      #1;

      // R2 direct mode, window boundaries
      tag_f = "R2"; det_mode = 2'd0; map_mode = 2'd0; tag_s = "R8";
      frame(0); frame(WIN); frame(WIN + 1); frame(2); frame(WIN + 3); frame(1);

      // R8 inverted / forced maps
      map_mode = 2'd1; frame(1); frame(WIN + 2);
      map_mode = 2'd2; frame(1); frame(WIN + 2);
      map_mode = 2'd3; frame(WIN + 2); frame(0);

      // R9 map and mode changes mid-field
      tag_s = "R9"; map_mode = 2'd0; frame(1);
      drive(1, 0); map_mode = 2'd1; drive(0, 0); det_mode = 2'd2; drive(0, 0);
      det_mode = 2'd0; map_mode = 2'd0; drive(0, 0);
      for (int i = 0; i < WIN + 3; i++) drive(0, 0);
      tag_s = "R8";

      // R3 / R10 locked detection: streaks and breaks
      tag_f = "R3"; det_mode = 2'd1;
      frame(WIN + 2); frame(WIN + 2); frame(1); frame(1); frame(1); frame(1);
      frame(WIN + 2); frame(WIN + 2); frame(1); frame(WIN + 2); frame(WIN + 2); frame(WIN + 2);

      // R4 toggle, H irrelevant
      tag_f = "R4"; det_mode = 2'd2;
      frame(0); frame(WIN + 2); frame(1);
      for (int i = 0; i < 6; i++) drive(0, (i % 2) == 1);

      // R5 spare code
      tag_f = "R5"; det_mode = 2'd3;
      frame(1); frame(WIN + 1); frame(WIN);

      // R6 source select with noise on the other pair
      tag_f = "R6"; det_mode = 2'd0;
      src_exp = 1'b1; drive(0, 0); frame(1, 1); frame(WIN + 2, 1); frame(0, 1);
      src_exp = 1'b0; drive(0, 0); frame(2, 1); frame(WIN + 2, 1);

      // R7 reversed polarities
      tag_f = "R7";
      h_rise = 1'b0; v_rise = 1'b0; drive(0, 0); drive(0, 0);
      frame(1); frame(WIN + 2); frame(WIN);
      h_rise = 1'b1; drive(0, 0); frame(2); frame(WIN + 1);
      v_rise = 1'b1; drive(0, 0);

      // random traffic across all modes
      tag_f = "R2";
      for (int i = 0; i < 3000; i++) begin
         if (i % 500 == 0) begin
            det_mode = 2'($urandom_range(3)); map_mode = 2'($urandom_range(3));
            tag_f = (det_mode == 2'd1) ? "R3" : (det_mode == 2'd2) ? "R4" : "R2";
         end
         dec_h = ($urandom_range(3) == 0) ? ~dec_h : dec_h;
         dec_v = ($urandom_range(15) == 0) ? ~dec_v : dec_v;
         exp_h = 1'($urandom_range(1)); exp_v = 1'($urandom_range(1));
         @(negedge clk); #1;
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule